// File: doc/BRIEF.md
# Fractional-N Real-Time Clock Prescaler

This block turns a fast system clock into the slow tick that advances a real-time clock's tick counter. The tick rate should come out at a nominal 32.768 kHz. An integer down-counter sets the base period. The fraction counter is free-running: it counts periods, moving on by one at each tick. A fraction value decides which integer periods get one extra input clock. Each fraction bit is tied to one bit pattern of the fraction counter. This spreads the lengthened periods evenly over the counter's cycle instead of grouping them.

Software loads two values through simple write strobes. One is the integer reload value, the other is the fraction value. The tick output is a one-cycle pulse, issued once per integer period. Over a full cycle of the fraction counter, the average period is the reload value plus one, plus the fraction value divided by 32768, in input clocks.

Top module: `rtc_prescaler`

## Requirements
- R1: While `rst_n` is low, `tick` is 0 and both counters and both value registers are cleared. The first rising clock edge after reset is released produces a tick, because the integer count starts at zero.
- R2: When the reload value is at least 1, `tick` is high for exactly one clock cycle per period.
- R3: A period that is not lengthened lasts reload+1 clock cycles, measured from one tick to the next.
- R4: A lengthened period lasts exactly reload+2 clock cycles. The extra cycle is held while the integer count sits at zero.
- R5: Let p be the fraction counter value in force during a period. Fraction bit (14−n) lengthens that period when bit n is the lowest set bit of p. In other words, the low n+1 bits of p are a 1 followed by n zeros. Bit 14 therefore acts on every odd p, and bit 13 acts when p ends in binary 10. When p is zero, no period is lengthened.
- R6: A period is lengthened by no more than one cycle, even when all fraction bits are set.
- R7: The fraction counter starts at zero after reset and advances by one on every tick, wrapping modulo 2^15. So the k-th period after reset uses the value k−1. Over any 2^15 consecutive periods, the number of extra cycles equals the fraction value.
- R8: A write to the integer register during a period does not change that period. The period that starts at the next tick uses the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| int_wr_en | input | 1 | Strobe that loads the integer reload value |
| int_wr_val | input | 13 | Integer reload value |
| frac_wr_en | input | 1 | Strobe that loads the fraction value |
| frac_wr_val | input | 15 | Fraction value, bit 14 weighs one half |
| tick | output | 1 | One-cycle pulse per integer period |

## Verification
The hardest behaviour to reach from the ports is the lowest-weight fraction bit. It acts only once in 32768 periods, when the fraction counter reaches 16384. The same holds for the claim that extras add up to exactly the fraction value over a whole counter cycle. The bench reaches both with the reload value at zero, where each period lasts one or two cycles. It then measures 32768 consecutive tick intervals, once with only the lowest bit set and once with a random fraction value. It also writes the reload value mid-period and checks that the current interval keeps the old length.

// File: rtl/prescale_pkg.sv
// Package: shared widths for the fractional prescaler.
// Assumes: one clock domain; widths fixed at chip level.
package prescale_pkg;
    localparam int INT_W  = 13;   // integer reload / down-counter width
    localparam int FRAC_W = 15;   // fraction register / counter width
endpackage

// File: rtl/prescale_frac_match.sv
// Module: prescale_frac_match
// Decides combinationally whether the current period needs one more clock.
// Fraction bit (W-1-n) is paired with "bit n is the lowest set bit of the
// period counter"; these conditions never overlap, so at most one fires.
// Assumes: both inputs are register outputs (no combinational loops).
module prescale_frac_match #(
    parameter int W = 15
) (
    input  logic [W-1:0] frac_val,
    input  logic [W-1:0] per_cnt,
    output logic [W-1:0] hit_vec,
    output logic         stretch_req
);
    genvar n;
    generate
        for (n = 0; n < W; n++) begin : g_pat
            if (n == 0) begin : g_lsb
                // pattern "1": counter bit 0 set
                assign hit_vec[n] = frac_val[W-1] & per_cnt[0];
            end else begin : g_hi
                // pattern "1 followed by n zeros" in the low n+1 bits
                assign hit_vec[n] = frac_val[W-1-n] & per_cnt[n]
                                    & ~(|per_cnt[n-1:0]);
            end
        end
    endgenerate

    // Any hit asks for one extra cycle in this period
    assign stretch_req = |hit_vec;
endmodule

// File: rtl/prescale_int_counter.sv
// Module: prescale_int_counter
// Integer down-counter with reload. At zero it either holds one more cycle
// (when a stretch is requested and not yet taken) or underflows and reloads.
// Assumes: reload value is sampled exactly at the underflow edge.
module prescale_int_counter #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] reload_val,
    input  logic         stretch_req,
    output logic         underflow,
    output logic         held,
    output logic [W-1:0] count
);
    logic at_zero;
    logic hold_now;

    assign at_zero   = (count == '0);
    assign hold_now  = at_zero & stretch_req & ~held;
    assign underflow = at_zero & ~hold_now;

    // Count down, hold one extra cycle at zero on request, reload on underflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            held  <= 1'b0;
        end else if (underflow) begin
            count <= reload_val;
            held  <= 1'b0;
        end else if (hold_now) begin
            held  <= 1'b1;
        end else begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/prescale_frac_counter.sv
// Module: prescale_frac_counter
// Free-running period counter; advances once per integer underflow and
// wraps modulo 2^W.
// Assumes: advance is a single-cycle strobe.
module prescale_frac_counter #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    output logic [W-1:0] value
);
    // Step by one per period, natural wrap
    always_ff @(posedge clk) begin
        if (!rst_n)       value <= '0;
        else if (advance) value <= value + 1'b1;
    end
endmodule

// File: rtl/rtc_prescaler.sv
// Module: rtc_prescaler (top)
// Fractional-N prescaler: integer period from a reload register, spread
// single-cycle extensions chosen by a fraction register, registered tick out.
// Assumes: write strobes are synchronous to clk; no bus decode here.
module rtc_prescaler
    import prescale_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_wr_en,
    input  logic [INT_W-1:0]  int_wr_val,
    input  logic              frac_wr_en,
    input  logic [FRAC_W-1:0] frac_wr_val,
    output logic              tick
);
    logic [INT_W-1:0]  reload_q;
    logic [FRAC_W-1:0] frac_q;
    logic [FRAC_W-1:0] fcnt_w;
    logic [FRAC_W-1:0] match_w;
    logic [INT_W-1:0]  cnt_w;
    logic              extend_w;
    logic              under_w;
    logic              stretch_w;
    logic              tick_q;

    // Hold the software-written integer and fraction values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            frac_q   <= '0;
        end else begin
            if (int_wr_en)  reload_q <= int_wr_val;
            if (frac_wr_en) frac_q   <= frac_wr_val;
        end
    end

    prescale_frac_match #(.W(FRAC_W)) u_match (
        .frac_val    (frac_q),
        .per_cnt     (fcnt_w),
        .hit_vec     (match_w),
        .stretch_req (extend_w)
    );

    prescale_int_counter #(.W(INT_W)) u_int (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload_val  (reload_q),
        .stretch_req (extend_w),
        .underflow   (under_w),
        .held        (stretch_w),
        .count       (cnt_w)
    );

    prescale_frac_counter #(.W(FRAC_W)) u_frac (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (under_w),
        .value   (fcnt_w)
    );

    // Register the underflow as the outgoing tick pulse
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= under_w;
    end

    assign tick = tick_q;
endmodule

// File: rtl/prescaler_chk.sv
// Module: prescaler_chk
// Temporal checks on the prescaler, bound into the top module.
// Assumes: synchronous active-low reset.
module prescaler_chk #(
    parameter int INT_W  = 13,
    parameter int FRAC_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [INT_W-1:0]  cnt,
    input logic [INT_W-1:0]  reload,
    input logic              stretch,
    input logic              extend,
    input logic [FRAC_W-1:0] fcnt,
    input logic [FRAC_W-1:0] match
);
    logic armed;

    // Mark that at least one clock edge has passed
    always_ff @(posedge clk) armed <= 1'b1;

    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    a_r4_one_extra: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |=> !stretch);

    a_r4_hold_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |-> (cnt == '0));

    a_r5_zero_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (fcnt == '0) |-> !extend);

    a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    a_r7_fcnt_step: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        tick |-> (fcnt == $past(fcnt) + 1'b1));

    a_r7_fcnt_idle: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !tick |-> $stable(fcnt));

    a_r8_reload_taken: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        tick |-> (cnt == $past(reload)));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != '0) |=> !tick);
endmodule

bind rtc_prescaler prescaler_chk #(.INT_W(prescale_pkg::INT_W), .FRAC_W(prescale_pkg::FRAC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cnt     (cnt_w),
    .reload  (reload_q),
    .stretch (stretch_w),
    .extend  (extend_w),
    .fcnt    (fcnt_w),
    .match   (match_w)
);

// File: tb/sim_rtc_prescaler.sv
`timescale 1ns/1ps
// Bench for rtc_prescaler: measures tick intervals and compares them with a
// model of period length computed from the requirements.
module sim_rtc_prescaler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_wr_en = 1'b0;
    logic [12:0] int_wr_val = '0;
    logic        frac_wr_en = 1'b0;
    logic [14:0] frac_wr_val = '0;
    logic        tick;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ntick = 0;
    int last_cyc = 0;
    bit have_last = 0;
    bit prev_tick = 0;
    bit chk_on = 0;
    bit sum_on = 0;
    bit sum_done = 0;
    int sum_acc = 0;
    int sum_n = 0;
    int exp_R = 0;
    logic [14:0] exp_F = '0;
    bit pend_v = 0;
    int pend_R = 0;
    string cur_tag = "R3";

    always #2 clk = ~clk;

    rtc_prescaler u0 (
        .clk(clk), .rst_n(rst_n),
        .int_wr_en(int_wr_en), .int_wr_val(int_wr_val),
        .frac_wr_en(frac_wr_en), .frac_wr_val(frac_wr_val),
        .tick(tick)
    );

    // Extra cycle expected for fraction f in a period with counter value p
    function automatic int ext_of(logic [14:0] f, logic [14:0] p);
        for (int n = 0; n < 15; n++)
            if (p[n]) return int'(f[14-n]);
        return 0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, expv, $time);
        end
    endtask

    // Interval monitor, sampled on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            ntick = 0; have_last = 0; prev_tick = 0;
        end else begin
            if (tick) begin
                if (have_last && chk_on) begin
                    int intv, e;
                    intv = cyc - last_cyc;
                    e = ext_of(exp_F, ntick[14:0]);
                    chk(intv == exp_R + 1 + e,
                        {"R3/R4 period ", cur_tag}, intv, exp_R + 1 + e);
                    if (exp_R > 0) chk(!prev_tick, "R2 pulse width", int'(prev_tick), 0);
                    if (sum_on) begin
                        sum_acc += intv - (exp_R + 1);
                        sum_n++;
                        if (sum_n == 32768) begin
                            chk(sum_acc == int'(exp_F), "R7 extras per cycle", sum_acc, int'(exp_F));
                            sum_on = 0; sum_done = 1;
                        end
                    end
                end
                if (pend_v) begin exp_R = pend_R; pend_v = 0; end
                have_last = 1; last_cyc = cyc; ntick++;
            end
            prev_tick = tick;
        end
    end

    task automatic wait_ticks(int n);
        repeat (n) begin
            @(negedge clk);
            while (!tick) @(negedge clk);
        end
    endtask

    task automatic wr_int(int v);
        int_wr_en = 1'b1; int_wr_val = v[12:0];
        @(negedge clk);
        int_wr_en = 1'b0;
    endtask

    task automatic wr_frac(logic [14:0] v);
        frac_wr_en = 1'b1; frac_wr_val = v;
        @(negedge clk);
        frac_wr_en = 1'b0;
    endtask

    task automatic cfg(int r, logic [14:0] f, string tag);
        chk_on = 0; sum_on = 0;
        wr_int(r);
        wr_frac(f);
        exp_R = r; exp_F = f; cur_tag = tag;
        wait_ticks(3);
        chk_on = 1;
    endtask

    task automatic long_sum(logic [14:0] f);
        cfg(0, f, "R7");
        sum_acc = 0; sum_n = 0; sum_done = 0;
        sum_on = 1;
        while (!sum_done) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still summarises
    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state and first tick
        repeat (4) @(negedge clk);
        chk(tick == 1'b0, "R1 tick in reset", int'(tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tick == 1'b1, "R1 first tick", int'(tick), 1);
        @(negedge clk);
        chk(tick == 1'b1, "R1 reload zero after reset", int'(tick), 1);

        // R3: plain integer periods
        cfg(9, 15'h0000, "R3");
        wait_ticks(6);
        // R5: single-bit fractions
        cfg(3, 15'h4000, "R5 half");
        wait_ticks(12);
        cfg(5, 15'h2000, "R5 quarter");
        wait_ticks(16);
        cfg(2, 15'h1000, "R5 eighth");
        wait_ticks(24);
        // R6: every fraction bit set
        cfg(4, 15'h7FFF, "R6 all bits");
        wait_ticks(40);
        cfg(0, 15'h7FFF, "R6 zero reload");
        wait_ticks(40);

        // R8: integer write mid-period applies at the next reload
        cfg(10, 15'h0000, "R8");
        wait_ticks(1);
        repeat (3) @(negedge clk);
        pend_R = 4; pend_v = 1;
        wr_int(4);
        wait_ticks(4);

        // Random mix of reload and fraction values
        for (int i = 0; i < 25; i++) begin
            int r;
            logic [14:0] f;
            r = int'($urandom_range(0, 20));
            f = 15'($urandom);
            cfg(r, f, "R4 random");
            wait_ticks(40);
        end

        // R7: full fraction-counter cycle, lowest bit then a random value
        long_sum(15'h0001);
        long_sum(15'($urandom));

        chk_on = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule